// File: doc/BRIEF.md
# Lockable Four-Way Set-Associative Cache

This block is a unified instruction and data cache that sits between a 32-bit processor and a line-oriented memory port. It stores 16 KB as four ways. Each way has 256 sets, and each set holds a 16-byte line of four 32-bit words. Every set keeps a tag, a valid bit and a dirty bit per way, plus a six-bit pairwise-age record for least-recently-used replacement. A lock input can take the two upper ways out of replacement. A locked way still returns hits and still accepts write hits.

The CPU holds a word request (`cpu_req` with address, write data, byte enables and attributes) until `cpu_rdy` pulses. Each access carries two attributes. `cpu_cacheable` sends an uncached access straight to memory as a single word. `cpu_wthru` chooses write-through (1) or write-back (0) for a cacheable write. The memory port carries single-word transfers and four-beat line bursts. Each beat is acknowledged by one `mem_ack` pulse. During a beat `mem_addr` shows that beat's word address, and the word offset rises 0, 1, 2, 3 through a burst. A one-cycle pulse on `inv_all` empties the whole cache.

The controller is one state machine with six states:
- IDLE looks up the tag. It goes to FLUSH on an invalidate (pending or current). It goes to RESP on a read hit or a write-back write hit. It goes to SINGLE on an uncached access, a write-through write hit or a write-through write miss. On an allocating miss it goes to WBACK when the victim is valid and dirty, and to REFILL otherwise.
- WBACK bursts the victim out and moves to REFILL after the last beat.
- REFILL loads the new line and returns to IDLE after the last beat. In IDLE the held request is then replayed and hits.
- SINGLE performs one word transfer and moves to RESP on its acknowledge.
- FLUSH clears every valid and dirty bit and the age records in one cycle, then returns to IDLE.
- RESP asserts `cpu_rdy` for one cycle and returns to IDLE.

Top module: `cache_ctrl`

## Requirements
- R1: A cacheable read that hits raises `cpu_rdy` in the cycle right after the request is first seen. It returns the cached word and makes no memory transfer.
- R2: `cpu_rdy` is high for exactly one cycle per access, and `cpu_rdata` is valid in that cycle for reads.
- R3: A read miss performs one four-beat read burst on the line base. The word offset `mem_addr[3:2]` goes 0,1,2,3, and the request then completes with the word that memory holds.
- R4: A write-back write hit merges the bytes whose `cpu_be` bit is set (bit n covers bits 8n+7..8n) into the cached word and sets the line dirty. It makes no memory transfer. A write-back write miss allocates the line first.
- R5: When the victim of an allocating miss is valid and dirty, its four words are burst to memory (`mem_we`=1) before the refill burst starts.
- R6: A write-through write hit updates the cached word and issues one single-word memory write with the same byte enables. The line stays clean, so its later eviction writes nothing back.
- R7: A write-through write miss issues one single-word memory write with no burst and does not allocate, so a later read of that line misses.
- R8: The victim is the least-recently-used way. Every hit and every fill makes its way most recent. After reset or invalidate, ways fill in order 0, 1, 2, 3.
- R9: `lock_ways[0]` excludes way 2 and `lock_ways[1]` excludes way 3 from replacement. The victim is then the LRU way among the unlocked ways, and locked lines keep returning hits.
- R10: An uncached access (`cpu_cacheable`=0) makes one single-word memory transfer. Cache contents are unchanged, and a dirty cached copy is neither read nor written.
- R11: An `inv_all` pulse takes priority over a pending request. It stalls the CPU while the cache is cleared in one FLUSH cycle, and it empties every line, so a following read misses.
- R12: After reset `cpu_rdy` and `mem_req` are low, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_cacheable | input | 1 | 1 = access goes through the cache |
| cpu_wthru | input | 1 | 1 = write-through, 0 = write-back |
| lock_ways | input | 2 | Bit 0 locks way 2, bit 1 locks way 3 |
| inv_all | input | 1 | Invalidate-all pulse |
| cpu_rdy | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with `cpu_rdy` |
| mem_req | output | 1 | Memory transfer active |
| mem_we | output | 1 | 1 = memory write |
| mem_burst | output | 1 | 1 = four-beat line burst |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_be | output | 4 | Byte enables of the current beat |
| mem_ack | input | 1 | Beat acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench drives several kinds of traffic and tells them apart by hit latency, burst counts and the bench's own memory image. The traffic includes cold read misses followed by hits, write-back writes with partial byte enables, and write-through writes that hit and that miss. It also includes uncached reads that land on a dirty cached line, and five or six tags that compete for one set. Hit or miss is judged from latency and the number of read bursts. Dirty and clean evictions are told apart by counting write beats. Plain LRU and lock-restricted LRU are told apart by first touching the would-be victims so that locking changes which lines survive.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_REFILL,
        ST_SINGLE,
        ST_FLUSH,
        ST_RESP
    } cache_state_t;

endpackage

// File: rtl/cache_way.sv
module cache_way #(
    parameter int SETS   = 256,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_all,
    input  logic [$clog2(SETS)-1:0]    idx,
    input  logic [$clog2(WORDS)-1:0]   rd_word,
    output logic [TAG_W-1:0]           rd_tag,
    output logic                       rd_valid,
    output logic                       rd_dirty,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       fill_en,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic                       wr_en,
    input  logic [$clog2(WORDS)-1:0]   wr_word,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [DATA_W/8-1:0]        wr_be,
    input  logic                       wr_dirty
);
    localparam int IDX_W = $clog2(SETS);
    localparam int OFF_W = $clog2(WORDS);
    localparam int BE_W  = DATA_W / 8;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS*WORDS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (clear_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (wr_en && wr_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_mem[idx] <= fill_tag;
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) data_mem[{idx, wr_word}][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign rd_tag   = tag_mem[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_data  = data_mem[{idx, rd_word}];

    logic [IDX_W+OFF_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_all,
    input  logic [$clog2(SETS)-1:0]   idx,
    input  logic                      touch_en,
    input  logic [$clog2(WAYS)-1:0]   touch_way,
    input  logic [WAYS-1:0]           excl,
    output logic [$clog2(WAYS)-1:0]   victim
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;

    // bit for pair (i<j) is 1 when way i was used more recently than way j
    logic [PAIRS-1:0] age_q [SETS];

    function automatic int pidx(input int i, input int j);
        return i * WAYS - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

    function automatic logic [PAIRS-1:0] touched(input logic [PAIRS-1:0] a, input int w);
        logic [PAIRS-1:0] r;
        r = a;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (i == w)      r[pidx(i, j)] = 1'b1;
                else if (j == w) r[pidx(i, j)] = 1'b0;
            end
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) age_q[s] <= '0;
        end else if (clear_all) begin
            for (int s = 0; s < SETS; s++) age_q[s] <= '0;
        end else if (touch_en) begin
            age_q[idx] <= touched(age_q[idx], int'(touch_way));
        end
    end

    always_comb begin
        logic [PAIRS-1:0] cur;
        logic found;
        logic oldest;
        cur    = age_q[idx];
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            oldest = !excl[w];
            for (int k = 0; k < WAYS; k++) begin
                if (k != w && !excl[k]) begin
                    if (w < k) begin
                        if (cur[pidx(w, k)]) oldest = 1'b0;
                    end else begin
                        if (!cur[pidx(k, w)]) oldest = 1'b0;
                    end
                end
            end
            if (oldest && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 256,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    parameter int LOCK_N = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W/8-1:0]   cpu_be,
    input  logic                  cpu_cacheable,
    input  logic                  cpu_wthru,
    input  logic [LOCK_N-1:0]     lock_ways,
    input  logic                  inv_all,
    output logic                  cpu_rdy,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic                  mem_burst,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_be,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata
);
    localparam int BE_W   = DATA_W / 8;
    localparam int BOFF_W = $clog2(BE_W);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    cache_state_t state_q, state_d;
    logic [OFF_W-1:0]  beat_q;
    logic [WAY_W-1:0]  vic_q;
    logic              inv_pend_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_word;
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[BOFF_W+OFF_W +: IDX_W];
    assign req_word = cpu_addr[BOFF_W +: OFF_W];

    logic [TAG_W-1:0]  way_tag   [WAYS];
    logic [DATA_W-1:0] way_rdata [WAYS];
    logic [WAYS-1:0]   way_valid, way_dirty, hit_vec, fill_en, wr_en;
    logic [OFF_W-1:0]  rd_word, wr_word;
    logic [DATA_W-1:0] wr_data;
    logic [BE_W-1:0]   wr_be;
    logic              wr_dirty, clear_all, touch_en, hit_any, flush_go, last_beat;
    logic [WAY_W-1:0]  touch_way, hit_way, lru_victim;
    logic [WAYS-1:0]   lock_excl;

    assign lock_excl = {lock_ways, {(WAYS-LOCK_N){1'b0}}};
    assign flush_go  = inv_all || inv_pend_q;
    assign last_beat = (beat_q == OFF_W'(WORDS-1));
    assign rd_word   = (state_q == ST_WBACK) ? beat_q : req_word;
    assign clear_all = (state_q == ST_FLUSH);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .idx(req_idx), .rd_word(rd_word),
            .rd_tag(way_tag[w]), .rd_valid(way_valid[w]), .rd_dirty(way_dirty[w]),
            .rd_data(way_rdata[w]), .fill_en(fill_en[w]), .fill_tag(req_tag),
            .wr_en(wr_en[w]), .wr_word(wr_word), .wr_data(wr_data), .wr_be(wr_be),
            .wr_dirty(wr_dirty)
        );
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit_any = |hit_vec;
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .idx(req_idx),
        .touch_en(touch_en), .touch_way(touch_way), .excl(lock_excl), .victim(lru_victim)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            beat_q     <= '0;
            vic_q      <= '0;
            inv_pend_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            state_q    <= state_d;
            inv_pend_q <= (inv_all && state_q != ST_IDLE) || (inv_pend_q && state_q != ST_FLUSH);
            if (state_q == ST_IDLE) begin
                beat_q <= '0;
                vic_q  <= lru_victim;
                if (!flush_go && cpu_req && cpu_cacheable && hit_any && !cpu_we)
                    rdata_q <= way_rdata[hit_way];
            end
            if ((state_q == ST_WBACK || state_q == ST_REFILL) && mem_ack)
                beat_q <= beat_q + OFF_W'(1);
            if (state_q == ST_SINGLE && mem_ack && !cpu_we)
                rdata_q <= mem_rdata;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_go)                             state_d = ST_FLUSH;
                else if (cpu_req) begin
                    if (!cpu_cacheable)                   state_d = ST_SINGLE;
                    else if (hit_any)                     state_d = (cpu_we && cpu_wthru) ? ST_SINGLE : ST_RESP;
                    else if (cpu_we && cpu_wthru)         state_d = ST_SINGLE;
                    else if (way_valid[lru_victim] && way_dirty[lru_victim])
                                                          state_d = ST_WBACK;
                    else                                  state_d = ST_REFILL;
                end
            end
            ST_WBACK:  if (mem_ack && last_beat) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack && last_beat) state_d = ST_IDLE;
            ST_SINGLE: if (mem_ack)              state_d = ST_RESP;
            ST_FLUSH:                            state_d = ST_IDLE;
            ST_RESP:                             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs and array controls
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        fill_en   = '0;
        wr_en     = '0;
        wr_word   = req_word;
        wr_data   = cpu_wdata;
        wr_be     = cpu_be;
        wr_dirty  = 1'b0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        unique case (state_q)
            ST_IDLE: begin
                if (!flush_go && cpu_req && cpu_cacheable && hit_any) begin
                    touch_en = 1'b1;
                    if (cpu_we) begin
                        wr_en[hit_way] = 1'b1;
                        wr_dirty       = !cpu_wthru;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {way_tag[vic_q], req_idx, beat_q, {BOFF_W{1'b0}}};
                mem_wdata = way_rdata[vic_q];
                mem_be    = '1;
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {req_tag, req_idx, beat_q, {BOFF_W{1'b0}}};
                mem_be    = '1;
                if (mem_ack) begin
                    wr_en[vic_q] = 1'b1;
                    wr_word      = beat_q;
                    wr_data      = mem_rdata;
                    wr_be        = '1;
                    if (last_beat) begin
                        fill_en[vic_q] = 1'b1;
                        touch_en       = 1'b1;
                        touch_way      = vic_q;
                    end
                end
            end
            ST_SINGLE: begin
                mem_req   = 1'b1;
                mem_we    = cpu_we;
                mem_addr  = cpu_addr & ~ADDR_W'(BE_W-1);
                mem_wdata = cpu_wdata;
                mem_be    = cpu_be;
            end
            ST_FLUSH, ST_RESP: ;
            default: ;
        endcase
    end

    assign cpu_rdy   = (state_q == ST_RESP);
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk
    import cache_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int OFF_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input cache_state_t             state,
    input logic                     cpu_req,
    input logic                     cpu_we,
    input logic                     cpu_wthru,
    input logic                     cpu_cacheable,
    input logic                     cpu_rdy,
    input logic                     mem_req,
    input logic                     mem_burst,
    input logic                     mem_ack,
    input logic [OFF_W-1:0]         mem_beat,
    input logic                     hit_any,
    input logic                     flush_go,
    input logic [$clog2(WAYS)-1:0]  victim,
    input logic [WAYS-1:0]          excl
);
    logic lookup;
    assign lookup = (state == ST_IDLE) && cpu_req && cpu_cacheable && !flush_go;

    AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy); // R2

    AST_READ_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && hit_any && !cpu_we) |=> cpu_rdy); // R1

    AST_BEAT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_burst && mem_ack && mem_beat != '1) |=>
            (mem_beat == OFF_W'($past(mem_beat) + 1'b1))); // R3

    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && !hit_any && !(cpu_we && cpu_wthru)) |-> !excl[victim]); // R9

    AST_WT_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && !hit_any && cpu_we && cpu_wthru) |=> (mem_req && !mem_burst)); // R7

    AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> (!cpu_rdy && !mem_req)); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> !hit_any); // R11
endmodule

bind cache_ctrl cache_ctrl_chk #(.WAYS(WAYS), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_wthru(cpu_wthru), .cpu_cacheable(cpu_cacheable), .cpu_rdy(cpu_rdy),
    .mem_req(mem_req), .mem_burst(mem_burst), .mem_ack(mem_ack),
    .mem_beat(mem_addr[BOFF_W +: OFF_W]), .hit_any(hit_any), .flush_go(flush_go),
    .victim(lru_victim), .excl(lock_excl)
);

// File: tb/cache_ctrl_test.sv
module cache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0, cpu_cacheable = 1, cpu_wthru = 0, inv_all = 0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [1:0]  lock_ways = '0;
    logic        cpu_rdy, mem_req, mem_we, mem_burst;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    cache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_cacheable(cpu_cacheable),
        .cpu_wthru(cpu_wthru), .lock_ways(lock_ways), .inv_all(inv_all), .cpu_rdy(cpu_rdy),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;
    int rd_beats = 0, wr_beats = 0, rd_bursts = 0, burst_pos = 0;
    logic [31:0] bmem [8192];
    logic [31:0] rd_v;
    int          cyc_v;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] adr(input int tag, input int set, input int word);
        return {tag[19:0], set[7:0], word[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // memory model: acknowledges every other cycle, one word per beat
    always @(posedge clk) begin
        int a;
        if (mem_req && !mem_ack) begin
            a = int'(mem_addr[14:2]);
            mem_ack <= 1'b1;
            if (mem_burst) begin
                chk(int'(mem_addr[3:2]) == burst_pos, "R3 burst word order", {30'd0, mem_addr[3:2]}, burst_pos);
                burst_pos = (burst_pos + 1) % 4;
            end
            if (mem_we) begin
                bmem[a] = merge(bmem[a], mem_wdata, mem_be);
                wr_beats++;
            end else begin
                mem_rdata <= bmem[a];
                rd_beats++;
                if (mem_burst && mem_addr[3:2] == 2'd0) rd_bursts++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input bit cach, input bit wt);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        cpu_cacheable = cach; cpu_wthru = wt;
        cyc_v = 0;
        do begin
            @(negedge clk);
            cyc_v++;
        end while (!cpu_rdy && cyc_v < 300);
        rd_v = cpu_rdata;
        cpu_req = 0; cpu_we = 0; cpu_cacheable = 1; cpu_wthru = 0;
    endtask

    task automatic rd(input logic [31:0] a);
        access(0, a, 32'h0, 4'h0, 1, 0);
    endtask

    task automatic flush();
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cpu_rdy == 0, "R12 rdy low after reset", {31'd0, cpu_rdy}, 0);
        chk(mem_req == 0, "R12 mem_req low after reset", {31'd0, mem_req}, 0);
        rd(adr(1, 3, 0));
        chk(rd_bursts == 1, "R12 first read misses", rd_bursts, 1);
    endtask

    task automatic t_read();
        int b;
        flush();
        b = rd_bursts;
        rd(adr(1, 2, 2));
        chk(rd_v == bmem[adr(1, 2, 2) >> 2], "R3 miss data", rd_v, bmem[adr(1, 2, 2) >> 2]);
        chk(rd_bursts == b + 1, "R3 one refill burst", rd_bursts, b + 1);
        rd(adr(1, 2, 3));
        chk(cyc_v == 1, "R1 hit latency", cyc_v, 1);
        chk(rd_v == bmem[adr(1, 2, 3) >> 2], "R1 hit data", rd_v, bmem[adr(1, 2, 3) >> 2]);
        chk(rd_bursts == b + 1, "R1 hit no traffic", rd_bursts, b + 1);
        @(negedge clk);
        chk(cpu_rdy == 0, "R2 rdy single pulse", {31'd0, cpu_rdy}, 0);
    endtask

    task automatic t_wback();
        int w;
        logic [31:0] old, exp;
        flush();
        old = bmem[adr(1, 5, 1) >> 2];
        w = wr_beats;
        access(1, adr(1, 5, 1), 32'h1111_2222, 4'hF, 1, 0);
        access(1, adr(1, 5, 1), 32'h00AB_0000, 4'b0100, 1, 0);
        chk(cyc_v == 1, "R4 write hit latency", cyc_v, 1);
        chk(wr_beats == w, "R4 no memory write", wr_beats, w);
        chk(bmem[adr(1, 5, 1) >> 2] == old, "R4 memory unchanged", bmem[adr(1, 5, 1) >> 2], old);
        exp = 32'h11AB_2222;
        rd(adr(1, 5, 1));
        chk(rd_v == exp, "R4 byte merge", rd_v, exp);
        for (int t = 2; t <= 4; t++) rd(adr(t, 5, 0));
        chk(wr_beats == w, "R5 no writeback yet", wr_beats, w);
        rd(adr(5, 5, 0));
        chk(wr_beats == w + 4, "R5 dirty line burst out", wr_beats, w + 4);
        chk(bmem[adr(1, 5, 1) >> 2] == exp, "R5 written back data", bmem[adr(1, 5, 1) >> 2], exp);
    endtask

    task automatic t_wthru();
        int w;
        logic [31:0] exp;
        flush();
        rd(adr(1, 9, 0));
        w = wr_beats;
        exp = merge(bmem[adr(1, 9, 2) >> 2], 32'h0000_5566, 4'b0011);
        access(1, adr(1, 9, 2), 32'h0000_5566, 4'b0011, 1, 1);
        chk(wr_beats == w + 1, "R6 single memory write", wr_beats, w + 1);
        chk(bmem[adr(1, 9, 2) >> 2] == exp, "R6 memory merged", bmem[adr(1, 9, 2) >> 2], exp);
        rd(adr(1, 9, 2));
        chk(cyc_v == 1 && rd_v == exp, "R6 cached copy updated", rd_v, exp);
        for (int t = 2; t <= 5; t++) rd(adr(t, 9, 0));
        chk(wr_beats == w + 1, "R6 clean eviction", wr_beats, w + 1);
    endtask

    task automatic t_wt_miss();
        int w, b;
        flush();
        w = wr_beats; b = rd_bursts;
        access(1, adr(1, 12, 0), 32'hCAFE_0007, 4'hF, 1, 1);
        chk(wr_beats == w + 1, "R7 single write", wr_beats, w + 1);
        chk(rd_bursts == b, "R7 no allocation", rd_bursts, b);
        rd(adr(1, 12, 0));
        chk(rd_bursts == b + 1, "R7 later read misses", rd_bursts, b + 1);
        chk(rd_v == 32'hCAFE_0007, "R7 data reached memory", rd_v, 32'hCAFE_0007);
    endtask

    task automatic t_lru();
        flush();
        for (int t = 1; t <= 4; t++) rd(adr(t, 20, 0));
        rd(adr(1, 20, 0));
        chk(cyc_v == 1, "R8 touch hit", cyc_v, 1);
        rd(adr(5, 20, 0));
        rd(adr(1, 20, 0)); chk(cyc_v == 1, "R8 recent line kept", cyc_v, 1);
        rd(adr(3, 20, 0)); chk(cyc_v == 1, "R8 line 3 kept", cyc_v, 1);
        rd(adr(4, 20, 0)); chk(cyc_v == 1, "R8 line 4 kept", cyc_v, 1);
        rd(adr(5, 20, 0)); chk(cyc_v == 1, "R8 new line present", cyc_v, 1);
        rd(adr(2, 20, 0)); chk(cyc_v > 1, "R8 LRU line evicted", cyc_v, 2);
    endtask

    task automatic t_lock();
        flush();
        for (int t = 1; t <= 4; t++) rd(adr(t, 30, 0));
        rd(adr(1, 30, 0));
        rd(adr(2, 30, 0));
        lock_ways = 2'b11;
        rd(adr(5, 30, 0));
        rd(adr(6, 30, 0));
        rd(adr(3, 30, 0)); chk(cyc_v == 1, "R9 locked way 2 kept and hits", cyc_v, 1);
        rd(adr(4, 30, 0)); chk(cyc_v == 1, "R9 locked way 3 kept and hits", cyc_v, 1);
        rd(adr(5, 30, 0)); chk(cyc_v == 1, "R9 fill in unlocked way", cyc_v, 1);
        rd(adr(6, 30, 0)); chk(cyc_v == 1, "R9 fill in unlocked way", cyc_v, 1);
        rd(adr(1, 30, 0)); chk(cyc_v > 1, "R9 unlocked LRU evicted", cyc_v, 2);
        lock_ways = 2'b00;
    endtask

    task automatic t_uncached();
        int rb, rbu, w;
        logic [31:0] old;
        flush();
        old = bmem[adr(1, 40, 0) >> 2];
        access(1, adr(1, 40, 0), 32'hDEAD_0001, 4'hF, 1, 0);
        rb = rd_beats; rbu = rd_bursts; w = wr_beats;
        access(0, adr(1, 40, 0), 32'h0, 4'h0, 0, 0);
        chk(rd_v == old, "R10 uncached read from memory", rd_v, old);
        chk(rd_beats == rb + 1 && rd_bursts == rbu, "R10 single beat", rd_beats, rb + 1);
        chk(wr_beats == w, "R10 dirty copy not written", wr_beats, w);
        rd(adr(1, 40, 0));
        chk(cyc_v == 1 && rd_v == 32'hDEAD_0001, "R10 cache untouched", rd_v, 32'hDEAD_0001);
    endtask

    task automatic t_flush();
        int b;
        rd(adr(2, 50, 1));
        rd(adr(2, 50, 1));
        chk(cyc_v == 1, "R11 line cached before invalidate", cyc_v, 1);
        b = rd_bursts;
        @(negedge clk);
        inv_all = 1; cpu_req = 1; cpu_we = 0; cpu_addr = adr(2, 50, 1); cpu_cacheable = 1;
        @(negedge clk);
        inv_all = 0;
        chk(cpu_rdy == 0, "R11 request stalled", {31'd0, cpu_rdy}, 0);
        cyc_v = 1;
        do begin @(negedge clk); cyc_v++; end while (!cpu_rdy && cyc_v < 300);
        rd_v = cpu_rdata;
        cpu_req = 0;
        chk(rd_bursts == b + 1, "R11 read after invalidate misses", rd_bursts, b + 1);
        chk(rd_v == bmem[adr(2, 50, 1) >> 2], "R11 data after refill", rd_v, bmem[adr(2, 50, 1) >> 2]);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) bmem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0101);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read();
        t_wback();
        t_wthru();
        t_wt_miss();
        t_lru();
        t_lock();
        t_uncached();
        t_flush();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule